// File: doc/BRIEF.md
# Event and Cycle Performance Counter Unit

This block counts hardware activity for profiling. It holds one free-running cycle counter and four 32-bit event counters. Each event counter watches one line of a 128-wide vector of single-cycle event pulses, and the line is chosen by a per-counter event number. Software drives the unit through a small register bus: a control word, enable set and clear words, an interrupt-enable set word, a pending-overflow word, a counter pointer, and an indirect window onto the event number and count of the counter the pointer names.

For sampling, software loads a counter with the negated period. When the count rolls over from all ones to zero, the counter's overflow bit is raised. If the interrupt for that counter is enabled, the level interrupt output goes high and stays high until software clears the bit by writing a one to it. The cycle counter can run at full clock rate or advance once every 64 clocks.

Top module: `pmu_counter_unit`

## Requirements
- R1: After reset every readable register and every counter reads zero, and `irq` is low. Addresses: 0 control, 1 enable-set, 2 enable-clear, 3 interrupt-enable-set, 4 overflow flags, 5 counter pointer, 6 event number window, 7 count window, 8 cycle count. Any other address reads zero.
- R2: The control word keeps only bits [5:0]. Bit 0 is the global run enable, bit 3 selects divide-by-64 for the cycle counter, and bits 4 and 5 are plain storage. Bits 1 and 2 read back as one for exactly one cycle after being written and then clear by themselves.
- R3: The enable-set, enable-clear, interrupt-enable-set and flag words share one layout: bits 0..3 are event counters 0..3 and bit 31 is the cycle counter. Writing a one to enable-set turns a counter on, writing a one to enable-clear turns it off, and zeros change nothing. Other bits are ignored and read zero. Addresses 1 and 2 both read the current enable mask.
- R4: An event counter adds one on each clock in which the global enable is set, its own enable is set, and the event input whose number it holds is high. Otherwise it holds its value.
- R5: With bit 3 clear, a running cycle counter adds one every clock. With bit 3 set, it adds one on the 64th running clock after its prescaler was last cleared, and then on every 64th running clock after that.
- R6: The pointer register stores 5 bits. Values 0..3 select an event counter for the event number and count windows. For any other value both windows read zero and writes to them are ignored.
- R7: The event number window stores only the low 7 bits of a write.
- R8: A counter that steps from 0xFFFFFFFF to 0 sets its overflow flag on the same clock. A bus write to a counter value takes priority over an increment on the same clock.
- R9: The flag word reads the pending overflow bits. Writing a one clears that bit, and writing a zero leaves it unchanged.
- R10: `irq` is high exactly when some flag bit and the matching interrupt-enable bit are both set. Interrupt enables are set by writing ones to address 3.
- R11: Control bit 1 zeroes all four event counters. Control bit 2 zeroes the cycle counter and its prescaler. Neither sets any flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWrite | input | 1 | Write strobe for one clock |
| regAddr | input | 4 | Register address |
| regWData | input | 32 | Write data |
| regRData | output | 32 | Combinational read data for `regAddr` |
| evtIn | input | 128 | Event pulse vector, indexed by event number |
| irq | output | 1 | Level overflow interrupt |

## Verification
The counting path is driven with pulses on the selected event line mixed with pulses on a neighbouring line. This separates a correct event-number mux from one that is off by one or ignores the selection. The same pulses are repeated with the global enable off and then with the counter's own enable off, to show that both gates act. The cycle counter is observed at full rate over ten clocks and in divide mode on both sides of the 64-clock boundary. The wrap tests preload all ones and all-ones-minus-one, collide a bus write with an event pulse, and let the cycle counter wrap with its interrupt masked, so that the flag and the interrupt are seen apart.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
  localparam int CNT_W    = 32;
  localparam int EVT_CNT  = 4;
  localparam int NCNT     = EVT_CNT + 1;
  localparam int CYC_IDX  = EVT_CNT;
  localparam int EVT_W    = 7;
  localparam int NUM_EVT  = 1 << EVT_W;
  localparam int SEL_W    = 5;
  localparam int IDX_W    = $clog2(EVT_CNT);
  localparam int CTRL_W   = 6;
  localparam int ADDR_W   = 4;
  localparam int DATA_W   = 32;
  localparam int CYC_BIT  = DATA_W - 1;

  localparam logic [ADDR_W-1:0] A_CTRL  = 4'd0;
  localparam logic [ADDR_W-1:0] A_ENSET = 4'd1;
  localparam logic [ADDR_W-1:0] A_ENCLR = 4'd2;
  localparam logic [ADDR_W-1:0] A_IESET = 4'd3;
  localparam logic [ADDR_W-1:0] A_FLAG  = 4'd4;
  localparam logic [ADDR_W-1:0] A_SEL   = 4'd5;
  localparam logic [ADDR_W-1:0] A_EVSEL = 4'd6;
  localparam logic [ADDR_W-1:0] A_EVCNT = 4'd7;
  localparam logic [ADDR_W-1:0] A_CYCNT = 4'd8;

  // Strobes and settings the control half hands to the datapath
  typedef struct packed {
    logic                             clrEvt;
    logic                             clrCyc;
    logic                             cycDiv;
    logic [NCNT-1:0]                  run;
    logic [EVT_CNT-1:0]               wrEvt;
    logic                             wrCyc;
    logic [CNT_W-1:0]                 wrData;
    logic [EVT_CNT-1:0][EVT_W-1:0]    evtSel;
  } strobeT;

  // Internal counter mask (cycle counter at the top index) to bus layout
  function automatic logic [DATA_W-1:0] toBus(input logic [NCNT-1:0] v);
    logic [DATA_W-1:0] b;
    b = '0;
    b[EVT_CNT-1:0] = v[EVT_CNT-1:0];
    b[CYC_BIT] = v[CYC_IDX];
    return b;
  endfunction

  function automatic logic [NCNT-1:0] fromBus(input logic [DATA_W-1:0] b);
    logic [NCNT-1:0] v;
    v[EVT_CNT-1:0] = b[EVT_CNT-1:0];
    v[CYC_IDX] = b[CYC_BIT];
    return v;
  endfunction
endpackage

// File: rtl/pmu_datapath.sv
module pmu_datapath
  import pmu_pkg::*;
#(
  parameter int PRESCALE_LOG2 = 6
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  strobeT                         strobe,
  input  logic [NUM_EVT-1:0]             evtIn,
  output logic [EVT_CNT-1:0][CNT_W-1:0]  evtCnt,
  output logic [CNT_W-1:0]               cycCnt,
  output logic [NCNT-1:0]                wrapVec
);
  logic [PRESCALE_LOG2-1:0] preCnt;
  logic                     cycTick;
  logic                     cycInc;
  logic [EVT_CNT-1:0]       hit;

  // Divide-by-2^PRESCALE_LOG2 prescaler for the cycle counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) preCnt <= '0;
    else if (strobe.clrCyc) preCnt <= '0;
    else if (strobe.run[CYC_IDX] && strobe.cycDiv) preCnt <= preCnt + 1'b1;
  end

  assign cycTick = strobe.cycDiv ? (&preCnt) : 1'b1;
  assign cycInc  = strobe.run[CYC_IDX] && cycTick;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cycCnt <= '0;
    else if (strobe.clrCyc) cycCnt <= '0;
    else if (strobe.wrCyc) cycCnt <= strobe.wrData;
    else if (cycInc) cycCnt <= cycCnt + 1'b1;
  end

  assign wrapVec[CYC_IDX] = cycInc && !strobe.wrCyc && !strobe.clrCyc && (&cycCnt);

  // Cycle counter stepping at full rate
  AST_CYC_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.run[CYC_IDX] && !strobe.cycDiv && !strobe.wrCyc && !strobe.clrCyc)
      |=> (cycCnt == $past(cycCnt) + 1'b1)); // R5

  AST_CYC_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    wrapVec[CYC_IDX] |=> (cycCnt == '0)); // R8

  for (genvar i = 0; i < EVT_CNT; i++) begin : gEvt
    assign hit[i] = strobe.run[i] && evtIn[strobe.evtSel[i]];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) evtCnt[i] <= '0;
      else if (strobe.clrEvt) evtCnt[i] <= '0;
      else if (strobe.wrEvt[i]) evtCnt[i] <= strobe.wrData;
      else if (hit[i]) evtCnt[i] <= evtCnt[i] + 1'b1;
    end

    assign wrapVec[i] = hit[i] && !strobe.wrEvt[i] && !strobe.clrEvt && (&evtCnt[i]);

    AST_EVT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
      (!strobe.run[i] && !strobe.wrEvt[i] && !strobe.clrEvt)
        |=> $stable(evtCnt[i])); // R4

    AST_EVT_WRITE_WINS: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.wrEvt[i] && !strobe.clrEvt)
        |=> (evtCnt[i] == $past(strobe.wrData))); // R8

    AST_EVT_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rstN)
      wrapVec[i] |=> (evtCnt[i] == '0)); // R8

    AST_EVT_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
      strobe.clrEvt |=> (evtCnt[i] == '0)); // R11
  end
endmodule

// File: rtl/pmu_ctrl.sv
module pmu_ctrl
  import pmu_pkg::*;
(
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           regWrite,
  input  logic [ADDR_W-1:0]              regAddr,
  input  logic [DATA_W-1:0]              regWData,
  output logic [DATA_W-1:0]              regRData,
  input  logic [NCNT-1:0]                wrapVec,
  input  logic [EVT_CNT-1:0][CNT_W-1:0]  evtCnt,
  input  logic [CNT_W-1:0]               cycCnt,
  output strobeT                         strobe,
  output logic                           irq
);
  logic [CTRL_W-1:0]             ctrlReg;
  logic [NCNT-1:0]               enReg;
  logic [NCNT-1:0]               irqEnReg;
  logic [NCNT-1:0]               flagReg;
  logic [SEL_W-1:0]              selReg;
  logic [EVT_CNT-1:0][EVT_W-1:0] evtSelReg;
  logic [NCNT-1:0]               busMask;
  logic [IDX_W-1:0]              selIdx;
  logic                          selValid;
  logic wrCtrl, wrEnSet, wrEnClr, wrIeSet, wrFlag, wrSel, wrEvSel, wrEvCnt, wrCyCnt;

  assign busMask  = fromBus(regWData);
  assign selIdx   = selReg[IDX_W-1:0];
  assign selValid = (selReg < SEL_W'(EVT_CNT));

  assign wrCtrl  = regWrite && (regAddr == A_CTRL);
  assign wrEnSet = regWrite && (regAddr == A_ENSET);
  assign wrEnClr = regWrite && (regAddr == A_ENCLR);
  assign wrIeSet = regWrite && (regAddr == A_IESET);
  assign wrFlag  = regWrite && (regAddr == A_FLAG);
  assign wrSel   = regWrite && (regAddr == A_SEL);
  assign wrEvSel = regWrite && (regAddr == A_EVSEL) && selValid;
  assign wrEvCnt = regWrite && (regAddr == A_EVCNT) && selValid;
  assign wrCyCnt = regWrite && (regAddr == A_CYCNT);

  // Control word: reset bits 1 and 2 live for a single cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ctrlReg <= '0;
    else if (wrCtrl) ctrlReg <= regWData[CTRL_W-1:0];
    else ctrlReg[2:1] <= 2'b00;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enReg    <= '0;
      irqEnReg <= '0;
      selReg   <= '0;
    end else begin
      if (wrEnSet) enReg <= enReg | busMask;
      else if (wrEnClr) enReg <= enReg & ~busMask;
      if (wrIeSet) irqEnReg <= irqEnReg | busMask;
      if (wrSel) selReg <= regWData[SEL_W-1:0];
    end
  end

  // New wraps win over a clear arriving in the same cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) flagReg <= '0;
    else flagReg <= (flagReg & ~(wrFlag ? busMask : '0)) | wrapVec;
  end

  for (genvar i = 0; i < EVT_CNT; i++) begin : gSel
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) evtSelReg[i] <= '0;
      else if (wrEvSel && (selIdx == IDX_W'(i))) evtSelReg[i] <= regWData[EVT_W-1:0];
    end

    always_comb begin
      strobe.wrEvt[i] = wrEvCnt && (selIdx == IDX_W'(i));
    end

    AST_FLAG_ON_WRAP: assert property (@(posedge clk) disable iff (!rstN)
      wrapVec[i] |=> flagReg[i]); // R8
  end

  always_comb begin
    strobe.clrEvt = ctrlReg[1];
    strobe.clrCyc = ctrlReg[2];
    strobe.cycDiv = ctrlReg[3];
    strobe.run    = enReg & {NCNT{ctrlReg[0]}};
    strobe.wrCyc  = wrCyCnt;
    strobe.wrData = regWData;
    strobe.evtSel = evtSelReg;
  end

  always_comb begin
    regRData = '0;
    case (regAddr)
      A_CTRL:  regRData[CTRL_W-1:0] = ctrlReg;
      A_ENSET: regRData = toBus(enReg);
      A_ENCLR: regRData = toBus(enReg);
      A_IESET: regRData = toBus(irqEnReg);
      A_FLAG:  regRData = toBus(flagReg);
      A_SEL:   regRData[SEL_W-1:0] = selReg;
      A_EVSEL: if (selValid) regRData[EVT_W-1:0] = evtSelReg[selIdx];
      A_EVCNT: if (selValid) regRData = evtCnt[selIdx];
      A_CYCNT: regRData = cycCnt;
      default: regRData = '0;
    endcase
  end

  assign irq = |(flagReg & irqEnReg);

  AST_CTRL_PULSE_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlReg[2:1] != 2'b00 && !wrCtrl) |=> (ctrlReg[2:1] == 2'b00)); // R2

  AST_CYC_FLAG_ON_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    wrapVec[CYC_IDX] |=> flagReg[CYC_IDX]); // R8

  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (wrFlag && regWData[0] && !wrapVec[0]) |=> !flagReg[0]); // R9

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (flagReg != '0)); // R10
endmodule

// File: rtl/pmu_counter_unit.sv
module pmu_counter_unit
  import pmu_pkg::*;
#(
  parameter int PRESCALE_LOG2 = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrite,
  input  logic [3:0]        regAddr,
  input  logic [31:0]       regWData,
  output logic [31:0]       regRData,
  input  logic [127:0]      evtIn,
  output logic              irq
);
  strobeT                        strobe;
  logic [EVT_CNT-1:0][CNT_W-1:0] evtCnt;
  logic [CNT_W-1:0]              cycCnt;
  logic [NCNT-1:0]               wrapVec;

  pmu_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .regWrite (regWrite),
    .regAddr  (regAddr),
    .regWData (regWData),
    .regRData (regRData),
    .wrapVec  (wrapVec),
    .evtCnt   (evtCnt),
    .cycCnt   (cycCnt),
    .strobe   (strobe),
    .irq      (irq)
  );

  pmu_datapath #(.PRESCALE_LOG2(PRESCALE_LOG2)) uData (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .evtIn   (evtIn),
    .evtCnt  (evtCnt),
    .cycCnt  (cycCnt),
    .wrapVec (wrapVec)
  );
endmodule

// File: tb/sim_pmu_counter_unit.sv
module sim_pmu_counter_unit;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         regWrite = 1'b0;
  logic [3:0]   regAddr = '0;
  logic [31:0]  regWData = '0;
  logic [31:0]  regRData;
  logic [127:0] evtIn = '0;
  logic         irq;
  int           nChecks = 0;
  int           nFails = 0;

  always #4 clk = ~clk; // 125 MHz

  pmu_counter_unit u0 (
    .clk(clk), .rstN(rstN), .regWrite(regWrite), .regAddr(regAddr),
    .regWData(regWData), .regRData(regRData), .evtIn(evtIn), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrite = 1'b1; regAddr = a; regWData = d;
    @(negedge clk);
    regWrite = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRData;
  endtask

  task automatic pulse(input int e);
    @(negedge clk);
    evtIn[e] = 1'b1;
    @(negedge clk);
    evtIn[e] = 1'b0;
  endtask

  task automatic tReset();
    logic [31:0] v;
    for (int a = 0; a < 16; a++) begin
      rd(4'(a), v);
      check("R1 reset read", v, 32'h0);
    end
    check("R1 irq low", {31'h0, irq}, 32'h0);
  endtask

  task automatic tCtrl();
    logic [31:0] v;
    wr(4'd0, 32'hFFFF_FFFF);
    rd(4'd0, v);
    check("R2 ctrl with pulses", v, 32'h3F);
    @(negedge clk);
    rd(4'd0, v);
    check("R2 ctrl pulses cleared", v, 32'h39);
    wr(4'd0, 32'h0);
  endtask

  task automatic tEnable();
    logic [31:0] v;
    wr(4'd1, 32'h8000_0005);
    rd(4'd1, v);
    check("R3 enable set", v, 32'h8000_0005);
    wr(4'd1, 32'h7FFF_FFF0);
    rd(4'd1, v);
    check("R3 unused bits ignored", v, 32'h8000_0005);
    wr(4'd2, 32'h0000_0004);
    rd(4'd2, v);
    check("R3 enable clear", v, 32'h8000_0001);
    wr(4'd2, 32'h8000_000F);
    rd(4'd1, v);
    check("R3 all cleared", v, 32'h0);
  endtask

  task automatic tEvent();
    logic [31:0] v;
    wr(4'd5, 32'h0);
    wr(4'd6, 32'hFFFF_FF85);
    rd(4'd6, v);
    check("R7 event number masked", v, 32'h05);
    wr(4'd7, 32'h0);
    wr(4'd1, 32'h1);
    wr(4'd0, 32'h1);
    pulse(5); pulse(6); pulse(5); pulse(6); pulse(5);
    rd(4'd7, v);
    check("R4 counts selected event only", v, 32'd3);
    wr(4'd0, 32'h0);
    pulse(5); pulse(5);
    rd(4'd7, v);
    check("R4 global enable gates", v, 32'd3);
    wr(4'd0, 32'h1);
    wr(4'd2, 32'h1);
    pulse(5);
    rd(4'd7, v);
    check("R4 own enable gates", v, 32'd3);
    wr(4'd0, 32'h0);
  endtask

  task automatic tCycle();
    logic [31:0] v;
    wr(4'd1, 32'h8000_0000);
    wr(4'd8, 32'h0);
    wr(4'd0, 32'h1);
    rd(4'd8, v);
    check("R5 cycle start", v, 32'd0);
    repeat (10) @(negedge clk);
    rd(4'd8, v);
    check("R5 full rate", v, 32'd10);
    wr(4'd0, 32'h0D);
    repeat (64) @(negedge clk);
    rd(4'd8, v);
    check("R5 div64 before boundary", v, 32'd0);
    @(negedge clk);
    rd(4'd8, v);
    check("R5 div64 at boundary", v, 32'd1);
    wr(4'd0, 32'h0);
    wr(4'd2, 32'h8000_0000);
  endtask

  task automatic tWrap();
    logic [31:0] v;
    wr(4'd5, 32'h0);
    wr(4'd7, 32'hFFFF_FFFE);
    wr(4'd1, 32'h1);
    wr(4'd3, 32'h1);
    wr(4'd0, 32'h1);
    pulse(5);
    rd(4'd7, v);
    check("R8 count at all ones", v, 32'hFFFF_FFFF);
    rd(4'd4, v);
    check("R8 no flag before wrap", v, 32'h0);
    pulse(5);
    rd(4'd7, v);
    check("R8 wrapped to zero", v, 32'h0);
    rd(4'd4, v);
    check("R8 flag on wrap", v, 32'h1);
    check("R10 irq with enable", {31'h0, irq}, 32'h1);
    @(negedge clk);
    regWrite = 1'b1; regAddr = 4'd7; regWData = 32'h100; evtIn[5] = 1'b1;
    @(negedge clk);
    regWrite = 1'b0; evtIn[5] = 1'b0;
    rd(4'd7, v);
    check("R8 write wins over increment", v, 32'h100);
    wr(4'd4, 32'h7FFF_FFFE);
    rd(4'd4, v);
    check("R9 zero bits keep flag", v, 32'h1);
    wr(4'd4, 32'h1);
    rd(4'd4, v);
    check("R9 write one clears", v, 32'h0);
    check("R10 irq drops", {31'h0, irq}, 32'h0);
    wr(4'd0, 32'h0);
    wr(4'd8, 32'hFFFF_FFFF);
    wr(4'd1, 32'h8000_0000);
    wr(4'd0, 32'h1);
    @(negedge clk);
    wr(4'd0, 32'h0);
    rd(4'd4, v);
    check("R8 cycle flag bit 31", v, 32'h8000_0000);
    check("R10 masked flag no irq", {31'h0, irq}, 32'h0);
    wr(4'd3, 32'h8000_0000);
    check("R10 irq after enable", {31'h0, irq}, 32'h1);
    rd(4'd3, v);
    check("R10 irq enable readback", v, 32'h8000_0001);
    wr(4'd4, 32'h8000_0000);
    check("R9 R10 cycle flag cleared", {31'h0, irq}, 32'h0);
    wr(4'd2, 32'h8000_000F);
  endtask

  task automatic tResetBits();
    logic [31:0] v;
    wr(4'd7, 32'h55);
    wr(4'd8, 32'h77);
    wr(4'd0, 32'h06);
    rd(4'd0, v);
    check("R2 reset bits visible one cycle", v, 32'h06);
    @(negedge clk);
    rd(4'd7, v);
    check("R11 event counters zeroed", v, 32'h0);
    rd(4'd8, v);
    check("R11 cycle counter zeroed", v, 32'h0);
    rd(4'd0, v);
    check("R2 reset bits self clear", v, 32'h0);
    rd(4'd4, v);
    check("R11 no flag from reset", v, 32'h0);
  endtask

  task automatic tSelect();
    logic [31:0] v;
    wr(4'd5, 32'hFF);
    rd(4'd5, v);
    check("R6 pointer 5 bits", v, 32'h1F);
    wr(4'd7, 32'h1234);
    wr(4'd6, 32'h33);
    rd(4'd7, v);
    check("R6 invalid window reads zero", v, 32'h0);
    rd(4'd6, v);
    check("R6 invalid event window zero", v, 32'h0);
    wr(4'd5, 32'h0);
    rd(4'd7, v);
    check("R6 invalid write ignored count", v, 32'h0);
    rd(4'd6, v);
    check("R6 invalid write ignored event", v, 32'h05);
    wr(4'd5, 32'h3);
    rd(4'd6, v);
    check("R6 counter 3 event untouched", v, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    tReset();
    tCtrl();
    tEnable();
    tEvent();
    tCycle();
    tWrap();
    tResetBits();
    tSelect();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule